// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a free-standing watchdog countdown with a compact word-addressed register file. Software drives it through one command register that only reacts to a handful of 16-bit magic values: one value opens the divider and reload registers for writing, another closes them, one launches the countdown and one reloads it (the "kick"). The countdown is clocked by a watchdog tick, given as a one-cycle enable `tick_en` in the `clk` domain, divided by a power-of-two ratio. When the count runs out, a one-cycle reset request leaves the block, the count is reloaded and the watchdog keeps going.

Configuration writes do not take effect at once. Each accepted divider or reload write is held in a shadow register and moved into the live copy after a fixed number of watchdog ticks. A busy flag per register shows that a transfer is still in flight, so software sets the divider and reload, launches the watchdog, polls until both flags are low and then kicks. Since the running state cannot be read back, software that finds the watchdog in an unknown state simply programs known values again. Once launched, the watchdog can only be stopped by the block reset.

Word offsets (byte address): command 0x00, divider 0x04, reload 0x08, busy flags 0x0C, 0x10 reserved (reads zero, writes dropped).

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the divider register reads 0, the reload register reads 0xFFF, the busy-flag register reads 0, the command register reads 0, and `rst_req` is low.
- R2: Writes to the divider (0x04) or reload (0x08) register are dropped unless the command value 0x5555 was written last among the locking commands; a dropped write leaves the read-back value unchanged and sets no busy flag.
- R3: Writing 0x0000, or any command value other than 0x5555, 0xCCCC and 0xAAAA, closes the configuration again; 0xCCCC and 0xAAAA leave the open/closed state unchanged.
- R4: The divider code in bits [CODE_W-1:0] selects a ratio of 2^(code+2); with a largest ratio of 256 the top code is 6, and a written code above the top code is stored and read back as the top code.
- R5: The reload register keeps only bits [11:0] of a write; higher data bits read back as zero.
- R6: An accepted divider write sets busy bit 0 and an accepted reload write sets busy bit 1 of register 0x0C on the next clock; the bit clears after APPLY_TICKS (3) further tick-enabled clocks, and all other bits of that register read as zero.
- R7: Before 0xCCCC is written, `rst_req` stays low; writing 0xCCCC loads the live reload value and starts the countdown, and the first request comes exactly (reload+1)·ratio ticks after that write, lasting one clock.
- R8: Writing 0xAAAA while running restarts the countdown from the live reload value, so the next request is (reload+1)·ratio ticks after it; 0xAAAA before the start has no effect.
- R9: After each request the counter reloads itself and a further request follows every (reload+1)·ratio ticks without any kick.
- R10: Once started, no command write (including 0x0000 or unknown values) stops the watchdog.
- R11: The divider and counter advance only on clocks where `tick_en` is high; with `tick_en` low the countdown holds.
- R12: A reload written while running is used only once its busy bit has cleared: a kick issued while it is in flight loads the old value, and the reload after the following expiry uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Watchdog tick enable, one pulse per tick |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The hardest situation to reach is a kick that lands while a reload update is still in flight, because it needs a shadow value different from the live one at the very moment the counter is reloaded, followed by an expiry that must pick up the new value. The stimulus writes a new reload, kicks on the very next clock and then measures both the first and the second expiry interval, which differ by a known amount. Around that, a sweep over every divider code and several reload values checks both the first and the repeating expiry interval against (reload+1)·2^(code+2), and a stretch with the tick held low shows the countdown frozen.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam int KEY_W = 16;
   localparam logic [KEY_W-1:0] CMD_START = 16'hCCCC;
   localparam logic [KEY_W-1:0] CMD_KICK  = 16'hAAAA;
   localparam logic [KEY_W-1:0] CMD_OPEN  = 16'h5555;
   localparam logic [KEY_W-1:0] CMD_CLOSE = 16'h0000;
   // word indices (byte offset / 4)
   localparam int SLOT_CMD  = 0;
   localparam int SLOT_DIV  = 1;
   localparam int SLOT_RLD  = 2;
   localparam int SLOT_BUSY = 3;
   localparam int SLOT_RSV  = 4;
endpackage

// File: rtl/wdg_keydec.sv
module wdg_keydec
   import wdg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [KEY_W-1:0] cmd_val,
   output logic             open_q,
   output logic             start_p,
   output logic             kick_p
);
   always_comb begin
      start_p = cmd_wr && (cmd_val == CMD_START);
      kick_p  = cmd_wr && (cmd_val == CMD_KICK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
      end else if (cmd_wr) begin
         if (cmd_val == CMD_OPEN)
            open_q <= 1'b1;
         else if (cmd_val != CMD_START && cmd_val != CMD_KICK)
            open_q <= 1'b0;   // CMD_CLOSE and every unknown value
      end
   end
endmodule

// File: rtl/wdg_cfg_slot.sv
module wdg_cfg_slot #(
   parameter int               W           = 12,
   parameter int               APPLY_TICKS = 3,
   parameter logic [W-1:0]     RESET_VAL   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_en,
   input  logic         wr_en,
   input  logic [W-1:0] wr_val,
   output logic [W-1:0] shadow_q,
   output logic [W-1:0] live_q,
   output logic         busy_q
);
   localparam int TW = $clog2(APPLY_TICKS + 1);

   logic [TW-1:0] wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= RESET_VAL;
         live_q   <= RESET_VAL;
         busy_q   <= 1'b0;
         wait_q   <= '0;
      end else if (wr_en) begin
         shadow_q <= wr_val;
         busy_q   <= 1'b1;
         wait_q   <= TW'(APPLY_TICKS);
      end else if (busy_q && tick_en) begin
         if (wait_q <= TW'(1)) begin
            live_q <= shadow_q;
            busy_q <= 1'b0;
            wait_q <= '0;
         end else begin
            wait_q <= wait_q - TW'(1);
         end
      end
   end
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
   parameter int CODE_W = 3,
   parameter int DIV_W  = 8,
   parameter int CNT_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              start,
   input  logic              kick,
   input  logic [CODE_W-1:0] code,
   input  logic [CNT_W-1:0]  reload,
   output logic              running_q,
   output logic              rst_req_q
);
   localparam int               CODE_MAX = DIV_W - 2;
   localparam logic [DIV_W-1:0] ONES     = '1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] div_lim;
   logic [CNT_W-1:0] cnt_q;

   // ratio - 1 = 2^(code+2) - 1
   assign div_lim = ONES >> (CODE_W'(CODE_MAX) - code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         rst_req_q <= 1'b0;
         div_q     <= '0;
         cnt_q     <= '0;
      end else begin
         rst_req_q <= 1'b0;
         if (start || (kick && running_q)) begin
            running_q <= 1'b1;
            div_q     <= '0;
            cnt_q     <= reload;
         end else if (running_q && tick_en) begin
            if (div_q >= div_lim) begin
               div_q <= '0;
               if (cnt_q == '0) begin
                  rst_req_q <= 1'b1;
                  cnt_q     <= reload;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end else begin
               div_q <= div_q + DIV_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import wdg_pkg::*;
#(
   parameter int MAX_RATIO   = 256,
   parameter int RELOAD_W    = 12,
   parameter int APPLY_TICKS = 3,
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              rst_req
);
   localparam int DIV_W    = $clog2(MAX_RATIO);
   localparam int CODE_MAX = DIV_W - 2;
   localparam int CODE_W   = $clog2(CODE_MAX + 1);
   localparam int WORD_W   = ADDR_W - 2;

   // elaboration-time parameter checks
   if (MAX_RATIO < 8 || (1 << DIV_W) != MAX_RATIO) begin : g_bad_ratio
      $error("MAX_RATIO must be a power of two of at least 8");
   end
   if (DATA_W < KEY_W || DATA_W < RELOAD_W) begin : g_bad_data
      $error("DATA_W too narrow for command or reload field");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must cover five word slots");
   end
   if (APPLY_TICKS < 1) begin : g_bad_apply
      $error("APPLY_TICKS must be at least 1");
   end

   logic [WORD_W-1:0] word;
   logic              sel_cmd, sel_div, sel_rld;
   logic              open_q, start_p, kick_p;
   logic [CODE_W-1:0] code_raw, code_in;
   logic [CODE_W-1:0] div_shadow, div_live;
   logic [RELOAD_W-1:0] rld_shadow, rld_live;
   logic              div_busy, rld_busy;
   logic              running;

   assign word    = reg_addr[ADDR_W-1:2];
   assign sel_cmd = reg_wr && (word == WORD_W'(SLOT_CMD));
   assign sel_div = reg_wr && (word == WORD_W'(SLOT_DIV)) && open_q;
   assign sel_rld = reg_wr && (word == WORD_W'(SLOT_RLD)) && open_q;

   wdg_keydec u_keydec (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_wr  (sel_cmd),
      .cmd_val (reg_wdata[KEY_W-1:0]),
      .open_q  (open_q),
      .start_p (start_p),
      .kick_p  (kick_p)
   );

   // divider code: saturate only when the field can hold codes above the top one
   assign code_raw = reg_wdata[CODE_W-1:0];
   if (((1 << CODE_W) - 1) == CODE_MAX) begin : g_code_exact
      assign code_in = code_raw;
   end else begin : g_code_sat
      assign code_in = (code_raw > CODE_W'(CODE_MAX)) ? CODE_W'(CODE_MAX) : code_raw;
   end

   wdg_cfg_slot #(
      .W           (CODE_W),
      .APPLY_TICKS (APPLY_TICKS),
      .RESET_VAL   ('0)
   ) u_div_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .wr_en    (sel_div),
      .wr_val   (code_in),
      .shadow_q (div_shadow),
      .live_q   (div_live),
      .busy_q   (div_busy)
   );

   wdg_cfg_slot #(
      .W           (RELOAD_W),
      .APPLY_TICKS (APPLY_TICKS),
      .RESET_VAL   ('1)
   ) u_rld_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .wr_en    (sel_rld),
      .wr_val   (reg_wdata[RELOAD_W-1:0]),
      .shadow_q (rld_shadow),
      .live_q   (rld_live),
      .busy_q   (rld_busy)
   );

   wdg_countdown #(
      .CODE_W (CODE_W),
      .DIV_W  (DIV_W),
      .CNT_W  (RELOAD_W)
   ) u_countdown (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .start     (start_p),
      .kick      (kick_p),
      .code      (div_live),
      .reload    (rld_live),
      .running_q (running),
      .rst_req_q (rst_req)
   );

   always_comb begin
      reg_rdata = '0;
      if (word == WORD_W'(SLOT_DIV))
         reg_rdata = DATA_W'(div_shadow);
      else if (word == WORD_W'(SLOT_RLD))
         reg_rdata = DATA_W'(rld_shadow);
      else if (word == WORD_W'(SLOT_BUSY))
         reg_rdata = DATA_W'({rld_busy, div_busy});
   end
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 16,
   parameter int CODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              rst_req,
   input logic              running,
   input logic              open_q,
   input logic [CODE_W-1:0] div_shadow,
   input logic              rld_busy
);
   logic [ADDR_W-3:0] w;
   assign w = reg_addr[ADDR_W-1:2];

   // R7
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !rst_req);
   // R10
   run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> running);
   // R2
   locked_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && w == (ADDR_W-2)'(1) && !open_q) |=> $stable(div_shadow));
   // R6
   busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && w == (ADDR_W-2)'(2) && open_q) |=> rld_busy);
   // R11
   tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(tick_en));
   // R6
   busy_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w == (ADDR_W-2)'(3)) |-> (reg_rdata[DATA_W-1:2] == '0));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CODE_W (CODE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_en    (tick_en),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_rdata  (reg_rdata),
   .rst_req    (rst_req),
   .running    (running),
   .open_q     (open_q),
   .div_shadow (div_shadow),
   .rld_busy   (rld_busy)
);

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
   localparam int APPLY = 3;
   localparam int TOPC  = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b1;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        rst_req;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   keyed_watchdog #(.MAX_RATIO(256), .APPLY_TICKS(APPLY)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rst_req(rst_req)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog: actual=timeout expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [15:0] s;
      for (int i = 0; i < 200; i++) begin
         rd(5'h0C, s);
         if (s == 16'h0) break;
         step();
      end
   endtask

   task automatic configure(input int code, input int rl);
      wr(5'h00, 16'h5555);
      wr(5'h04, 16'(code));
      wr(5'h08, 16'(rl));
      wait_idle();
   endtask

   // pulses expected exactly at edges first and first+gap after the last write
   task automatic expect_pulses(input int first, input int gap, input string req);
      int bad_k = 0;
      bit bad = 0;
      int bad_v = 0;
      for (int k = 1; k <= first + gap; k++) begin
         step();
         if (!bad && rst_req !== ((k == first) || (k == first + gap))) begin
            bad = 1; bad_k = k; bad_v = rst_req;
         end
      end
      if (bad) $display("  mismatch at edge %0d of %0d/%0d", bad_k, first, gap);
      check(!bad, req, bad_v, bad ? !bad_v : 0);
   endtask

   task automatic expect_quiet(input int n, input string req);
      int seen = 0;
      for (int k = 1; k <= n; k++) begin
         step();
         if (rst_req) seen++;
      end
      check(seen == 0, req, seen, 0);
   endtask

   initial begin
      logic [15:0] v;
      int rls[4] = '{0, 1, 2, 6};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(5'h04, v); check(v == 16'h0,   "R1 divider", v, 0);
      rd(5'h08, v); check(v == 16'hFFF, "R1 reload", v, 16'hFFF);
      rd(5'h0C, v); check(v == 16'h0,   "R1 busy", v, 0);
      rd(5'h00, v); check(v == 16'h0,   "R1 command", v, 0);
      check(rst_req == 1'b0, "R1 rst_req", rst_req, 0);

      // R2 closed writes dropped
      wr(5'h04, 16'h3);
      rd(5'h0C, v); check(v == 16'h0, "R2 no busy", v, 0);
      wr(5'h08, 16'h5);
      rd(5'h04, v); check(v == 16'h0,   "R2 divider kept", v, 0);
      rd(5'h08, v); check(v == 16'hFFF, "R2 reload kept", v, 16'hFFF);

      // R6 busy timing, R4 readback, R5 masking
      wr(5'h00, 16'h5555);
      wr(5'h04, 16'h0003);
      rd(5'h0C, v); check(v == 16'h1, "R6 div busy set", v, 1);
      step(); step();
      rd(5'h0C, v); check(v == 16'h1, "R6 div busy held", v, 1);
      step();
      rd(5'h0C, v); check(v == 16'h0, "R6 div busy clear", v, 0);
      rd(5'h04, v); check(v == 16'h3, "R4 divider readback", v, 3);
      wr(5'h08, 16'hF123);
      rd(5'h0C, v); check(v == 16'h2, "R6 reload busy set", v, 2);
      rd(5'h08, v); check(v == 16'h123, "R5 reload mask", v, 16'h123);
      wait_idle();
      rd(5'h10, v); check(v == 16'h0, "R6 reserved reads zero", v, 0);
      wr(5'h04, 16'h0007);
      rd(5'h04, v); check(v == 16'(TOPC), "R4 code saturates", v, TOPC);
      wait_idle();

      // R3 closing commands
      wr(5'h00, 16'h0000);
      wr(5'h04, 16'h0001);
      rd(5'h04, v); check(v == 16'(TOPC), "R3 close key", v, TOPC);
      wr(5'h00, 16'h5555);
      wr(5'h00, 16'h1234);
      wr(5'h08, 16'h0055);
      rd(5'h08, v); check(v == 16'h123, "R3 unknown key closes", v, 16'h123);
      wr(5'h00, 16'h5555);
      wr(5'h00, 16'hAAAA);
      wr(5'h08, 16'h0044);
      rd(5'h08, v); check(v == 16'h044, "R3 kick keeps open", v, 16'h44);
      wait_idle();

      // R7/R8 before start
      configure(0, 2);
      wr(5'h00, 16'hAAAA);
      expect_quiet(200, "R8 kick before start");
      // R7 start, R9 repeat
      wr(5'h00, 16'hCCCC);
      expect_pulses(12, 12, "R7 start expiry");

      // R8 restart mid-count
      wr(5'h00, 16'hAAAA);
      expect_quiet(8, "R8 quiet before restart");
      wr(5'h00, 16'hAAAA);
      expect_pulses(12, 12, "R8 restart");

      // R4/R9 sweep over every code and several reloads
      for (int c = 0; c <= TOPC; c++) begin
         for (int j = 0; j < 4; j++) begin
            int n;
            n = (rls[j] + 1) * (1 << (c + 2));
            configure(c, rls[j]);
            wr(5'h00, 16'hAAAA);
            expect_pulses(n, n, $sformatf("R4 R9 code=%0d reload=%0d", c, rls[j]));
         end
      end

      // R11 tick gating
      configure(0, 2);
      tick_en = 1'b0;
      wr(5'h00, 16'hAAAA);
      expect_quiet(300, "R11 held without tick");
      tick_en = 1'b1;
      expect_pulses(12, 12, "R11 resumes with tick");

      // R12 in-flight reload
      wr(5'h08, 16'd9);
      wr(5'h00, 16'hAAAA);
      expect_pulses(12, 40, "R12 old then new reload");

      // R10 cannot stop
      configure(0, 2);
      wr(5'h00, 16'h0000);
      wr(5'h00, 16'h7777);
      wr(5'h00, 16'hAAAA);
      expect_pulses(12, 12, "R10 still running");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule